// File: doc/BRIEF.md
# Memory Region Steering Decoder

This block decides, for every memory access in the upper part of a 1 MB real-mode address space, whether the access is served by the system-board memory or forwarded to the expansion I/O channel. The space from 0x40000 up to 0xFFFFF is cut into 16 KB blocks. In the middle area (0x40000 to 0xBFFFF) each block has one steering bit that routes both reads and writes. In the top area (0xC0000 to 0xFFFFF) each block also has its own steering bit. A block whose bit is clear falls back to a shadow setting that is shared by its 64 KB group, with independent read and write routes.

Configuration arrives as plain vectors from the surrounding register file. The low-area bitmap is 32 bits and the top-area bitmap is 16 bits. The shadow byte holds read routes in its lower nibble and write routes in its upper nibble. The decode itself is combinational. Its result is registered, so the route for an access is presented one clock after the access is offered.

Top module: `msd_route_decoder`

## Requirements
- R1: While `rst` is high and on the first clock after it, `route_valid`, `route_ext` and `route_hit` are 0.
- R2: The outputs follow the inputs of the previous clock. When `acc_valid` was 0, all three outputs are 0. When `acc_valid` was 1, `route_valid` is 1.
- R3: An access below 0x40000 gives `route_ext`=0 and `route_hit`=0, whatever the configuration holds.
- R4: An access from 0x40000 to 0xFFFFF gives `route_hit`=1.
- R5: In 0x40000–0xBFFFF the block number is c=(addr−0x40000)>>14, from 0 to 31. `cfg_low_map[c]` chooses the route for both reads and writes. Bit c is bit c%8 of byte c/8, and byte 0 is the least significant byte. A 1 selects the I/O channel (`route_ext`=1).
- R6: In 0xC0000–0xFFFFF the block number is c=(addr−0xC0000)>>14, from 0 to 15. When `cfg_high_map[c]`=1, both reads and writes go external.
- R7: A read in a top-area block with `cfg_high_map[c]`=0 takes its route from `cfg_shadow[3−g]`, where g=c>>2. A value of 1 means external.
- R8: A write in a top-area block with `cfg_high_map[c]`=0 takes its route from `cfg_shadow[7−g]`. A value of 1 means external. This route does not depend on the read bits.
- R9: Each bitmap bit affects only its own 16 KB block. With a single bit set, only that block routes external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is offered this cycle |
| acc_addr | input | 20 | Physical address of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| cfg_shadow | input | 8 | Shadow routes of the top area: bits 3..0 for reads, bits 7..4 for writes |
| cfg_low_map | input | 32 | Per-block steering bits for 0x40000–0xBFFFF |
| cfg_high_map | input | 16 | Per-block steering bits for 0xC0000–0xFFFFF |
| route_valid | output | 1 | Registered result is valid |
| route_ext | output | 1 | 1 sends the access to the I/O channel, 0 to system-board memory |
| route_hit | output | 1 | The address lay inside the decoded range |

## Verification
The assertions run on every cycle. They check the reset and idle behaviour and the one-cycle timing. They also check that low addresses always stay internal and that the hit flag matches the range. Two saturated cases are covered as well: all-ones and all-zeros bitmaps in the low area, and shadow settings in the top area. The mapping from each bitmap bit and shadow bit to its particular block or group depends on the exact configuration, so only the bench can show it. The bench sweeps every block for reads and writes under random configurations, and a directed single-bit sweep shows that bits do not leak into neighbouring blocks.

// File: rtl/msd_pkg.sv
package msd_pkg;

  // Coarse area an address falls into
  typedef enum logic [1:0] {
    AREA_BELOW = 2'd0,
    AREA_MID   = 2'd1,
    AREA_TOP   = 2'd2
  } area_e;

  typedef struct packed {
    logic ext;
    logic hit;
  } route_t;

endpackage

// File: rtl/msd_block_locate.sv
module msd_block_locate #(
  parameter int ADDR_W      = 20,
  parameter int BLK_LOG2    = 14,
  parameter int LOW_FIRST   = 16,
  parameter int LOW_BLOCKS  = 32,
  parameter int HIGH_BLOCKS = 16,
  localparam int LOW_IDX_W  = $clog2(LOW_BLOCKS),
  localparam int HIGH_IDX_W = $clog2(HIGH_BLOCKS)
) (
  input  logic [ADDR_W-1:0]     addr,
  output msd_pkg::area_e        area,
  output logic [LOW_IDX_W-1:0]  low_idx,
  output logic [HIGH_IDX_W-1:0] high_idx
);
  localparam int BLK_W      = ADDR_W - BLK_LOG2;
  localparam int HIGH_FIRST = LOW_FIRST + LOW_BLOCKS;

  logic [BLK_W-1:0] blk;
  logic [BLK_W-1:0] low_off;
  logic [BLK_W-1:0] high_off;

  assign blk      = addr[ADDR_W-1:BLK_LOG2];
  assign low_off  = blk - BLK_W'(LOW_FIRST);
  assign high_off = blk - BLK_W'(HIGH_FIRST);
  assign low_idx  = low_off[LOW_IDX_W-1:0];
  assign high_idx = high_off[HIGH_IDX_W-1:0];

  always_comb begin
    if (blk < BLK_W'(LOW_FIRST))       area = msd_pkg::AREA_BELOW;
    else if (blk < BLK_W'(HIGH_FIRST)) area = msd_pkg::AREA_MID;
    else                               area = msd_pkg::AREA_TOP;
  end
endmodule

// File: rtl/msd_bit_pick.sv
module msd_bit_pick #(
  parameter int N       = 32,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_o
);
  logic [N-1:0] hits;

  // And-or selection tree: one decoded term per bitmap bit (R9)
  for (genvar i = 0; i < N; i++) begin : g_term
    assign hits[i] = vec[i] & (idx == IDX_W'(i));
  end

  assign bit_o = |hits;
endmodule

// File: rtl/msd_shadow_route.sv
module msd_shadow_route #(
  parameter int GROUPS = 4,
  localparam int GRP_W = $clog2(GROUPS)
) (
  input  logic [2*GROUPS-1:0] shadow,
  input  logic [GRP_W-1:0]    grp,
  input  logic                is_write,
  output logic                ext
);
  logic [GROUPS-1:0] rd_sel;
  logic [GROUPS-1:0] wr_sel;

  // Group g reads from bit GROUPS-1-g (R7), writes from bit 2*GROUPS-1-g (R8)
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign rd_sel[g] = shadow[GROUPS-1-g];
    assign wr_sel[g] = shadow[2*GROUPS-1-g];
  end

  assign ext = is_write ? wr_sel[grp] : rd_sel[grp];
endmodule

// File: rtl/msd_route_decoder.sv
module msd_route_decoder #(
  parameter int ADDR_W      = 20,
  parameter int BLK_LOG2    = 14,
  parameter int LOW_FIRST   = 16,
  parameter int LOW_BLOCKS  = 32,
  parameter int HIGH_BLOCKS = 16,
  parameter int GROUPS      = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_valid,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic                   acc_write,
  input  logic [2*GROUPS-1:0]    cfg_shadow,
  input  logic [LOW_BLOCKS-1:0]  cfg_low_map,
  input  logic [HIGH_BLOCKS-1:0] cfg_high_map,
  output logic                   route_valid,
  output logic                   route_ext,
  output logic                   route_hit
);
  localparam int LOW_IDX_W  = $clog2(LOW_BLOCKS);
  localparam int HIGH_IDX_W = $clog2(HIGH_BLOCKS);
  localparam int GRP_W      = $clog2(GROUPS);

  msd_pkg::area_e         area;
  logic [LOW_IDX_W-1:0]   low_idx;
  logic [HIGH_IDX_W-1:0]  high_idx;
  logic                   low_bit;
  logic                   high_bit;
  logic                   shadow_ext;
  msd_pkg::route_t        route_d;

  msd_block_locate #(
    .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .LOW_FIRST(LOW_FIRST),
    .LOW_BLOCKS(LOW_BLOCKS), .HIGH_BLOCKS(HIGH_BLOCKS)
  ) i_locate (
    .addr(acc_addr), .area(area), .low_idx(low_idx), .high_idx(high_idx)
  );

  msd_bit_pick #(.N(LOW_BLOCKS)) i_low_pick (
    .vec(cfg_low_map), .idx(low_idx), .bit_o(low_bit)
  );

  msd_bit_pick #(.N(HIGH_BLOCKS)) i_high_pick (
    .vec(cfg_high_map), .idx(high_idx), .bit_o(high_bit)
  );

  msd_shadow_route #(.GROUPS(GROUPS)) i_shadow (
    .shadow(cfg_shadow),
    .grp(high_idx[HIGH_IDX_W-1 -: GRP_W]),
    .is_write(acc_write),
    .ext(shadow_ext)
  );

  always_comb begin
    route_d = '0;
    unique case (area)
      msd_pkg::AREA_MID: begin
        route_d.hit = 1'b1;
        route_d.ext = low_bit;
      end
      msd_pkg::AREA_TOP: begin
        route_d.hit = 1'b1;
        route_d.ext = high_bit | shadow_ext;
      end
      default: route_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_valid <= 1'b0;
      route_ext   <= 1'b0;
      route_hit   <= 1'b0;
    end else begin
      route_valid <= acc_valid;
      route_ext   <= acc_valid & route_d.ext;
      route_hit   <= acc_valid & route_d.hit;
    end
  end
endmodule

// File: rtl/msd_route_checker.sv
module msd_route_checker #(
  parameter int ADDR_W      = 20,
  parameter int BLK_LOG2    = 14,
  parameter int LOW_FIRST   = 16,
  parameter int LOW_BLOCKS  = 32,
  parameter int HIGH_BLOCKS = 16,
  parameter int GROUPS      = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   acc_valid,
  input logic [ADDR_W-1:0]      acc_addr,
  input logic                   acc_write,
  input logic [2*GROUPS-1:0]    cfg_shadow,
  input logic [LOW_BLOCKS-1:0]  cfg_low_map,
  input logic [HIGH_BLOCKS-1:0] cfg_high_map,
  input logic                   route_valid,
  input logic                   route_ext,
  input logic                   route_hit
);
  localparam int BLK_W      = ADDR_W - BLK_LOG2;
  localparam int HIGH_FIRST = LOW_FIRST + LOW_BLOCKS;

  logic [BLK_W-1:0] blk;
  logic in_low, in_high, below;
  assign blk     = acc_addr[ADDR_W-1:BLK_LOG2];
  assign below   = blk < BLK_W'(LOW_FIRST);
  assign in_high = !below && !(blk < BLK_W'(HIGH_FIRST));
  assign in_low  = !below && !in_high;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !route_valid && !route_ext && !route_hit);

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !route_valid && !route_ext && !route_hit);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> route_valid);

  p_below_internal_r3: assert property (@(posedge clk) disable iff (rst)
    acc_valid && below |=> !route_ext && !route_hit);

  p_range_hit_r4: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !below |=> route_hit);

  p_mid_all_ext_r5: assert property (@(posedge clk) disable iff (rst)
    acc_valid && in_low && (&cfg_low_map) |=> route_ext);

  p_mid_all_int_r5: assert property (@(posedge clk) disable iff (rst)
    acc_valid && in_low && cfg_low_map == '0 |=> !route_ext);

  p_top_forced_r6: assert property (@(posedge clk) disable iff (rst)
    acc_valid && in_high && (&cfg_high_map) |=> route_ext);

  p_top_read_int_r7: assert property (@(posedge clk) disable iff (rst)
    acc_valid && in_high && !acc_write && cfg_high_map == '0
      && cfg_shadow[GROUPS-1:0] == '0 |=> !route_ext);

  p_top_write_ext_r8: assert property (@(posedge clk) disable iff (rst)
    acc_valid && in_high && acc_write && (&cfg_shadow[2*GROUPS-1:GROUPS])
      |=> route_ext);
endmodule

bind msd_route_decoder msd_route_checker #(
  .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .LOW_FIRST(LOW_FIRST),
  .LOW_BLOCKS(LOW_BLOCKS), .HIGH_BLOCKS(HIGH_BLOCKS), .GROUPS(GROUPS)
) i_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_write(acc_write), .cfg_shadow(cfg_shadow), .cfg_low_map(cfg_low_map),
  .cfg_high_map(cfg_high_map), .route_valid(route_valid),
  .route_ext(route_ext), .route_hit(route_hit)
);

// File: tb/test_msd_route_decoder.sv
module test_msd_route_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [19:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [7:0]  cfg_shadow = '0;
  logic [31:0] cfg_low_map = '0;
  logic [15:0] cfg_high_map = '0;
  logic        route_valid, route_ext, route_hit;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  msd_route_decoder i_msd_route_decoder (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .cfg_shadow(cfg_shadow), .cfg_low_map(cfg_low_map),
    .cfg_high_map(cfg_high_map), .route_valid(route_valid),
    .route_ext(route_ext), .route_hit(route_hit)
  );

  // Behavioural reference of the requirements
  function automatic bit model_ext(int a, bit wr, logic [7:0] sh,
                                   logic [31:0] lo, logic [15:0] hi);
    int c, g;
    if (a < 'h40000) return 0;
    if (a < 'hC0000) begin
      c = (a - 'h40000) / 'h4000;
      return lo[c];
    end
    c = (a - 'hC0000) / 'h4000;
    if (hi[c]) return 1;
    g = c / 4;
    return wr ? sh[7 - g] : sh[3 - g];
  endfunction

  function automatic string req_of(int a, bit wr, logic [15:0] hi);
    if (a < 'h40000) return "R3";
    if (a < 'hC0000) return "R5";
    if (hi[(a - 'hC0000) / 'h4000]) return "R6";
    return wr ? "R8" : "R7";
  endfunction

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d (addr=%05h wr=%0d)",
               req, got, exp, acc_addr, acc_write);
    end
  endtask

  // Offer one access at a falling edge, check the registered result one clock later
  task automatic access(bit v, int a, bit wr, string tag);
    bit exp_ext;
    @(negedge clk);
    acc_valid = v;
    acc_addr  = 20'(a);
    acc_write = wr;
    exp_ext   = v && model_ext(a, wr, cfg_shadow, cfg_low_map, cfg_high_map);
    @(negedge clk);
    check("R2", route_valid, v);
    if (tag.len() != 0) check(tag, route_ext, exp_ext);
    else check(req_of(a, wr, cfg_high_map), route_ext, exp_ext);
    check(v && a >= 'h40000 ? "R4" : "R3", route_hit, v && a >= 'h40000);
  endtask

  initial begin
    // R1: reset holds outputs low even with an access offered
    acc_valid = 1'b1; acc_addr = 20'hC4000; cfg_high_map = '1;
    repeat (3) @(negedge clk);
    check("R1", route_valid, 0);
    check("R1", route_ext, 0);
    check("R1", route_hit, 0);
    rst = 1'b0; acc_valid = 1'b0;
    @(negedge clk);
    check("R1", route_valid, 0);

    // R2: idle cycles give all-zero outputs
    access(0, 'hC4000, 0, "R2");
    access(0, 'h50000, 1, "R2");

    // R3: below the range with everything set
    cfg_low_map = '1; cfg_high_map = '1; cfg_shadow = '1;
    access(1, 'h00000, 0, "R3");
    access(1, 'h3FFFF, 1, "R3");
    access(1, 'h40000, 0, "R5");
    access(1, 'hFFFFF, 1, "R6");

    // R7/R8: independent read and write routes for each group
    cfg_high_map = '0; cfg_low_map = '0;
    for (int s = 0; s < 256; s += 17) begin
      cfg_shadow = 8'(s);
      for (int g = 0; g < 4; g++) begin
        access(1, 'hC0000 + g * 'h10000 + 'h1234, 0, "R7");
        access(1, 'hC0000 + g * 'h10000 + 'hFFFF, 1, "R8");
      end
    end

    // R9: a single bit reaches only its own block
    cfg_shadow = '0;
    for (int b = 0; b < 32; b++) begin
      cfg_low_map = 32'(1) << b;
      for (int k = 16; k < 48; k++) access(1, k * 'h4000, k[0], "R9");
    end
    cfg_low_map = '0;
    for (int b = 0; b < 16; b++) begin
      cfg_high_map = 16'(1) << b;
      for (int k = 48; k < 64; k++) access(1, k * 'h4000 + 'h3FFF, k[1], "R9");
    end

    // Random configurations, every block, reads and writes
    for (int n = 0; n < 40; n++) begin
      cfg_low_map  = $urandom;
      cfg_high_map = 16'($urandom);
      cfg_shadow   = 8'($urandom);
      for (int k = 0; k < 64; k++)
        for (int w = 0; w < 2; w++)
          access(1, k * 'h4000 + int'($urandom % 'h4000), w[0], "");
    end

    // Synchronous reset mid-run clears outputs (R1)
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 20'hFC000; cfg_high_map = '1; rst = 1'b1;
    @(negedge clk);
    check("R1", route_ext, 0);
    check("R1", route_valid, 0);
    rst = 1'b0; acc_valid = 1'b0;

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule